// File: doc/BRIEF.md
# Bridge Current Chopper with Selectable Decay

This block is the digital controller for one full bridge that drives a single motor winding. A fixed-length PWM period starts on every period boundary, and a new step event restarts the period at once. At the start of a period the block switches on the diagonal that drives current in the commanded direction. An external comparator reports when the high-side sensed current has reached the setpoint. The block then ends the on-time and recirculates the winding current for the rest of the period, in one of four ways. Slow decay turns on both high sides. Fast decay turns on the opposite diagonal. Mixed decay runs a fast interval followed by slow decay. Auto decay picks slow or a fast-type decay according to how the step setpoint moved.

Every half bridge has its own dead-time gate. When either of its switches turns off, the other switch is held off for a time set by the slew-rate code. The block drives the four gate enables, a duty signal that is high during the on-time, the enable for that duty signal, and an open-load flag. The flag is based on how many PWM periods in a row never reach the limit. The analog sensing, the comparators and the gate drivers sit outside the block.

Top module: `chopper_bridge`

## Requirements
- R1: While reset is held, and just after it, all four gate enables are low, the duty output is low and the open-load flag is low.
- R2: A period begins every PERIOD_CLKS clocks, and one clock after a cycle with step_pulse high. At period start the bridge drives: with dir_fwd=1 the gates gate_hs[0] and gate_ls[1] turn on; with dir_fwd=0 the gates gate_hs[1] and gate_ls[0] turn on.
- R3: The on-time ends only on a clock where hs_over_lim is sampled high during the on-time. The off-time then lasts until the period ends.
- R4: Slow decay (decay_sel=0) turns on gate_hs[1:0]=2'b11 with both low sides off.
- R5: Fast decay (decay_sel=1) turns on the diagonal opposite to the drive diagonal and holds it until the period ends.
- R6: Mixed decay (decay_sel=2) first turns on the fast diagonal and then moves to slow decay. With mix_by_sense=0 the fast interval lasts fast_time clocks. With mix_by_sense=1 it ends when ls_under_lim is high.
- R7: In auto decay (decay_sel=3), slow decay is used when the limit_mag sampled at the latest step is greater than the value sampled at the step before. Otherwise mixed decay is used.
- R8: The two switches of one half bridge are never on together. After either switch turns off, the other stays off for at least 2*(slew_sel+1) clocks (DT_UNIT=2).
- R9: pwm_duty is high exactly while the on-time is active and pwm_out_en is 1. pwm_duty_oe follows pwm_out_en.
- R10: open_load goes high after OL_CYCLES (15) periods in a row in which hs_over_lim never occurred during the on-time. A period that reaches the limit clears it.
- R11: bridge_en=0 forces all four gates and pwm_duty low in the same clock cycle. The block then restarts from a new period once bridge_en returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bridge_en | input | 1 | Bridge enable; low forces all gates off |
| dir_fwd | input | 1 | Commanded current direction |
| step_pulse | input | 1 | New step event; restarts the PWM period |
| limit_mag | input | LIM_W | Setpoint magnitude sampled at each step (auto decay) |
| decay_sel | input | 2 | 0 slow, 1 fast, 2 mixed, 3 auto |
| mix_by_sense | input | 1 | Mixed fast interval ends on sense (1) or on time (0) |
| fast_time | input | FT_W | Fixed fast-interval length in clocks |
| slew_sel | input | SLEW_W | Slew code; dead time = DT_UNIT*(slew_sel+1) |
| hs_over_lim | input | 1 | High-side sense has reached the limit |
| ls_under_lim | input | 1 | Low-side sense has dropped below the limit |
| pwm_out_en | input | 1 | Enable for the duty output |
| gate_hs | output | 2 | High-side gate enables, index 0 and 1 per half bridge |
| gate_ls | output | 2 | Low-side gate enables, index 0 and 1 per half bridge |
| pwm_duty | output | 1 | High during the on-time |
| pwm_duty_oe | output | 1 | Output enable of pwm_duty |
| open_load | output | 1 | Limit not reached for OL_CYCLES periods in a row |

## Verification
The hardest state to reach from the ports is the end of the open-load window. It needs fifteen whole periods in a row with no comparator event and no step in between. The stimulus therefore issues one step, keeps hs_over_lim low for about thirteen periods and checks that the flag is still low, then waits past the fifteenth period and checks that it is high. It then clears the flag with a single comparator pulse. The dead-time checks need both directions of every half-bridge swap under more than one slew code. For that, the sequence goes from slow decay to reverse drive, then to fast decay and to mixed decay with slew_sel at its maximum, while a monitor measures each gap.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;

   typedef enum logic [1:0] {
      PH_OFF   = 2'd0,
      PH_DRIVE = 2'd1,
      PH_FAST  = 2'd2,
      PH_SLOW  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      DK_SLOW  = 2'd0,
      DK_FAST  = 2'd1,
      DK_MIXED = 2'd2,
      DK_AUTO  = 2'd3
   } decay_e;

   typedef struct packed {
      logic [1:0] hs;
      logic [1:0] ls;
   } gates_t;

   // Requested switch pattern for a phase; index 0/1 selects the half bridge
   function automatic gates_t phase_gates(input phase_e ph, input logic fwd);
      gates_t g;
      g.hs = 2'b00;
      g.ls = 2'b00;
      case (ph)
         PH_DRIVE: begin
            g.hs = fwd ? 2'b01 : 2'b10;
            g.ls = fwd ? 2'b10 : 2'b01;
         end
         PH_FAST: begin
            g.hs = fwd ? 2'b10 : 2'b01;
            g.ls = fwd ? 2'b01 : 2'b10;
         end
         PH_SLOW: g.hs = 2'b11;
         default: ;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/chop_period_timer.sv
`timescale 1ns/1ps
module chop_period_timer #(
   parameter int PERIOD_CLKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic pstart
);
   localparam int CW = (PERIOD_CLKS > 2) ? $clog2(PERIOD_CLKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD_CLKS - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || restart || cnt == LAST) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign pstart = run && (cnt == '0);

   // R2
   step_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart && run ##1 run |-> pstart);

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

endmodule

// File: rtl/chop_phase_ctrl.sv
`timescale 1ns/1ps
module chop_phase_ctrl
   import chop_pkg::*;
#(
   parameter int LIM_W           = 5,
   parameter int FT_W            = 6,
   parameter bit AUTO_FALL_MIXED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             pstart,
   input  logic             step,
   input  logic [LIM_W-1:0] limit_mag,
   input  logic [1:0]       decay_sel,
   input  logic             mix_by_sense,
   input  logic [FT_W-1:0]  fast_time,
   input  logic             hs_over_lim,
   input  logic             ls_under_lim,
   output phase_e           phase,
   output logic             reached,
   output logic             active
);
   logic [LIM_W-1:0] last_lim;
   logic             rising;
   decay_e           fall_mode;
   decay_e           sel_mode;
   decay_e           eff_mode;
   logic             mixing;
   logic [FT_W-1:0]  fcnt;
   logic [FT_W:0]    fcnt_next;
   logic             fast_done;

   // Setpoint history for auto decay
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_lim <= '0;
         rising   <= 1'b0;
      end else if (step) begin
         rising   <= (limit_mag > last_lim);
         last_lim <= limit_mag;
      end
   end

   generate
      if (AUTO_FALL_MIXED) begin : g_fall_mixed
         assign fall_mode = DK_MIXED;
      end else begin : g_fall_fast
         assign fall_mode = DK_FAST;
      end
   endgenerate

   assign sel_mode = decay_e'(decay_sel);

   always_comb begin
      if (sel_mode == DK_AUTO) begin
         eff_mode = rising ? DK_SLOW : fall_mode;
      end else begin
         eff_mode = sel_mode;
      end
   end

   assign fcnt_next = {1'b0, fcnt} + 1'b1;
   assign fast_done = mix_by_sense ? ls_under_lim : (fcnt_next >= {1'b0, fast_time});

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         phase  <= PH_OFF;
         mixing <= 1'b0;
         fcnt   <= '0;
      end else if (pstart) begin
         phase  <= PH_DRIVE;
         mixing <= 1'b0;
         fcnt   <= '0;
      end else begin
         case (phase)
            PH_DRIVE: begin
               if (hs_over_lim) begin
                  case (eff_mode)
                     DK_SLOW: phase <= PH_SLOW;
                     DK_FAST: begin
                        phase  <= PH_FAST;
                        mixing <= 1'b0;
                     end
                     default: begin
                        phase  <= PH_FAST;
                        mixing <= 1'b1;
                        fcnt   <= '0;
                     end
                  endcase
               end
            end
            PH_FAST: begin
               if (mixing) begin
                  if (fast_done) begin
                     phase  <= PH_SLOW;
                     mixing <= 1'b0;
                  end else begin
                     fcnt <= fcnt_next[FT_W-1:0];
                  end
               end
            end
            PH_SLOW: ;
            default: phase <= PH_OFF;
         endcase
      end
   end

   // Per-period limit tracking for open-load
   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         reached <= 1'b0;
         active  <= 1'b0;
      end else begin
         if (pstart) begin
            reached <= 1'b0;
         end else if (phase == PH_DRIVE && hs_over_lim) begin
            reached <= 1'b1;
         end
         if (phase == PH_DRIVE) begin
            active <= 1'b1;
         end
      end
   end

   // R3
   drive_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_DRIVE) && $past(phase == PH_DRIVE) && $past(run) && run |-> $past(hs_over_lim));

   // R4
   slow_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SLOW) && $past(phase != PH_SLOW) |-> $past(phase == PH_DRIVE || (phase == PH_FAST && mixing)));

   // R5
   fast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FAST) && !mixing && run && !pstart |=> phase == PH_FAST);

   // R7
   auto_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run && !pstart && phase == PH_DRIVE && hs_over_lim && decay_sel == 2'd3 && rising) && run
      |-> phase == PH_SLOW);

endmodule

// File: rtl/chop_dead_gate.sv
`timescale 1ns/1ps
module chop_dead_gate #(
   parameter int DT_UNIT = 2,
   parameter int SLEW_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              want_hs,
   input  logic              want_ls,
   input  logic [SLEW_W-1:0] slew_sel,
   output logic              hs_q,
   output logic              ls_q
);
   localparam int DMAX = DT_UNIT * (2 ** SLEW_W);
   localparam int CW   = $clog2(DMAX + 1);

   logic [CW-1:0] dead_len;
   logic [CW-1:0] cnt;
   logic          hs_nxt;
   logic          ls_nxt;
   logic          turn_off;

   assign dead_len = CW'(DT_UNIT * (int'(slew_sel) + 1));

   // A switch already on may stay on; a new turn-on waits for the other
   // switch to be off and the dead-time counter to be empty.
   assign hs_nxt   = want_hs && (hs_q || (!ls_q && cnt == '0));
   assign ls_nxt   = want_ls && (ls_q || (!hs_q && cnt == '0));
   assign turn_off = (hs_q && !hs_nxt) || (ls_q && !ls_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         hs_q <= 1'b0;
         ls_q <= 1'b0;
         cnt  <= '0;
      end else begin
         hs_q <= hs_nxt;
         ls_q <= ls_nxt;
         if (turn_off) begin
            cnt <= dead_len;
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // Independent gap measurement for the checks below
   logic [CW:0] idle_run;
   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         idle_run <= '1;
      end else if (hs_q || ls_q) begin
         idle_run <= '0;
      end else if (idle_run != '1) begin
         idle_run <= idle_run + 1'b1;
      end
   end

   // R8
   no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_q && ls_q));

   // R8
   dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs_q) || $rose(ls_q)) |-> idle_run >= {1'b0, dead_len});

endmodule

// File: rtl/chop_openload.sv
`timescale 1ns/1ps
module chop_openload #(
   parameter int OL_CYCLES = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic pstart,
   input  logic active,
   input  logic reached,
   output logic open_load
);
   localparam int OW = $clog2(OL_CYCLES + 1);
   localparam logic [OW-1:0] OL_MAX = OW'(OL_CYCLES);

   logic [OW-1:0] miss;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         miss <= '0;
      end else if (pstart && active) begin
         if (reached) begin
            miss <= '0;
         end else if (miss != OL_MAX) begin
            miss <= miss + 1'b1;
         end
      end
   end

   assign open_load = (miss == OL_MAX);

   // R10
   ol_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_load) |-> $past(pstart));

   // R10
   ol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(open_load) && $past(run) |-> $past(reached));

endmodule

// File: rtl/chopper_bridge.sv
`timescale 1ns/1ps
module chopper_bridge
   import chop_pkg::*;
#(
   parameter int PERIOD_CLKS     = 64,
   parameter int LIM_W           = 5,
   parameter int FT_W            = 6,
   parameter int SLEW_W          = 2,
   parameter int DT_UNIT         = 2,
   parameter int OL_CYCLES       = 15,
   parameter bit AUTO_FALL_MIXED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bridge_en,
   input  logic              dir_fwd,
   input  logic              step_pulse,
   input  logic [LIM_W-1:0]  limit_mag,
   input  logic [1:0]        decay_sel,
   input  logic              mix_by_sense,
   input  logic [FT_W-1:0]   fast_time,
   input  logic [SLEW_W-1:0] slew_sel,
   input  logic              hs_over_lim,
   input  logic              ls_under_lim,
   input  logic              pwm_out_en,
   output logic [1:0]        gate_hs,
   output logic [1:0]        gate_ls,
   output logic              pwm_duty,
   output logic              pwm_duty_oe,
   output logic              open_load
);
   localparam int NHALF = 2;

   generate
      if (PERIOD_CLKS < 8) begin : g_bad_period
         $error("PERIOD_CLKS must be at least 8");
      end
      if (DT_UNIT < 1) begin : g_bad_dt
         $error("DT_UNIT must be at least 1");
      end
      if (OL_CYCLES < 1) begin : g_bad_ol
         $error("OL_CYCLES must be at least 1");
      end
      if (LIM_W < 1 || FT_W < 1 || SLEW_W < 1) begin : g_bad_width
         $error("field widths must be positive");
      end
   endgenerate

   logic       pstart;
   phase_e     phase;
   logic       reached;
   logic       active;
   gates_t     want;
   logic [1:0] hs_raw;
   logic [1:0] ls_raw;

   chop_period_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (bridge_en),
      .restart (step_pulse),
      .pstart  (pstart)
   );

   chop_phase_ctrl #(
      .LIM_W           (LIM_W),
      .FT_W            (FT_W),
      .AUTO_FALL_MIXED (AUTO_FALL_MIXED)
   ) u_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (bridge_en),
      .pstart       (pstart),
      .step         (step_pulse),
      .limit_mag    (limit_mag),
      .decay_sel    (decay_sel),
      .mix_by_sense (mix_by_sense),
      .fast_time    (fast_time),
      .hs_over_lim  (hs_over_lim),
      .ls_under_lim (ls_under_lim),
      .phase        (phase),
      .reached      (reached),
      .active       (active)
   );

   always_comb want = phase_gates(phase, dir_fwd);

   generate
      for (genvar h = 0; h < NHALF; h++) begin : g_half
         chop_dead_gate #(.DT_UNIT(DT_UNIT), .SLEW_W(SLEW_W)) u_dg (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (bridge_en),
            .want_hs  (want.hs[h]),
            .want_ls  (want.ls[h]),
            .slew_sel (slew_sel),
            .hs_q     (hs_raw[h]),
            .ls_q     (ls_raw[h])
         );

         // R8
         port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hs[h] && gate_ls[h]));
      end
   endgenerate

   chop_openload #(.OL_CYCLES(OL_CYCLES)) u_ol (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (bridge_en),
      .pstart    (pstart),
      .active    (active),
      .reached   (reached),
      .open_load (open_load)
   );

   assign gate_hs     = hs_raw & {NHALF{bridge_en}};
   assign gate_ls     = ls_raw & {NHALF{bridge_en}};
   assign pwm_duty    = (phase == PH_DRIVE) && pwm_out_en && bridge_en;
   assign pwm_duty_oe = pwm_out_en;

   // R11
   disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bridge_en) |-> (hs_raw == 2'b00 && ls_raw == 2'b00));

   // R9
   duty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_duty) && $past(bridge_en) && $past(pwm_out_en) |-> $past(pstart));

endmodule

// File: tb/chopper_bridge_test.sv
`timescale 1ns/1ps
module chopper_bridge_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bridge_en = 1'b0;
   logic       dir_fwd = 1'b1;
   logic       step_pulse = 1'b0;
   logic [4:0] limit_mag = 5'd10;
   logic [1:0] decay_sel = 2'd0;
   logic       mix_by_sense = 1'b0;
   logic [5:0] fast_time = 6'd20;
   logic [1:0] slew_sel = 2'd0;
   logic       hs_over_lim = 1'b0;
   logic       ls_under_lim = 1'b0;
   logic       pwm_out_en = 1'b1;
   logic [1:0] gate_hs;
   logic [1:0] gate_ls;
   logic       pwm_duty;
   logic       pwm_duty_oe;
   logic       open_load;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   always #2.5 clk = ~clk;

   chopper_bridge uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bridge_en    (bridge_en),
      .dir_fwd      (dir_fwd),
      .step_pulse   (step_pulse),
      .limit_mag    (limit_mag),
      .decay_sel    (decay_sel),
      .mix_by_sense (mix_by_sense),
      .fast_time    (fast_time),
      .slew_sel     (slew_sel),
      .hs_over_lim  (hs_over_lim),
      .ls_under_lim (ls_under_lim),
      .pwm_out_en   (pwm_out_en),
      .gate_hs      (gate_hs),
      .gate_ls      (gate_ls),
      .pwm_duty     (pwm_duty),
      .pwm_duty_oe  (pwm_duty_oe),
      .open_load    (open_load)
   );

   // Scoreboard item: {hs[1:0], ls[1:0], duty, oe, open_load}
   typedef struct {
      string      tag;
      logic [6:0] exp;
      logic [6:0] mask;
   } item_t;

   item_t sb_q[$];

   // Monitor: compares queued expectations at the next falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [6:0] act;
            it  = sb_q.pop_front();
            act = {gate_hs, gate_ls, pwm_duty, pwm_duty_oe, open_load};
            n_checks++;
            if ((act & it.mask) !== (it.exp & it.mask)) begin
               n_fails++;
               $display("FAIL %s: got hs=%b ls=%b duty=%b oe=%b ol=%b, expected hs=%b ls=%b duty=%b oe=%b ol=%b (mask %b)",
                        it.tag, act[6:5], act[4:3], act[2], act[1], act[0],
                        it.exp[6:5], it.exp[4:3], it.exp[2], it.exp[1], it.exp[0], it.mask);
            end
         end
      end
   end

   // Dead-time and exclusivity monitor (R8)
   int   gap   [2];
   bit   armed [2];
   logic p_hs  [2];
   logic p_ls  [2];
   initial begin
      for (int h = 0; h < 2; h++) begin
         gap[h] = 0; armed[h] = 1'b0; p_hs[h] = 1'b0; p_ls[h] = 1'b0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         for (int h = 0; h < 2; h++) begin
            int exp_d;
            exp_d = 2 * (int'(slew_sel) + 1);
            if ((gate_hs[h] && gate_ls[h]) || (p_hs[h] && gate_ls[h]) || (p_ls[h] && gate_hs[h])) begin
               n_checks++;
               n_fails++;
               $display("FAIL R8 half %0d: direct swap or overlap hs=%b ls=%b, expected a dead gap", h, gate_hs[h], gate_ls[h]);
            end
            if ((gate_hs[h] || gate_ls[h]) && !(p_hs[h] || p_ls[h])) begin
               if (armed[h]) begin
                  n_checks++;
                  if (gap[h] < exp_d) begin
                     n_fails++;
                     $display("FAIL R8 half %0d: dead gap %0d, expected >= %0d", h, gap[h], exp_d);
                  end
                  armed[h] = 1'b0;
               end
            end else if (!(gate_hs[h] || gate_ls[h]) && (p_hs[h] || p_ls[h])) begin
               armed[h] = 1'b1;
               gap[h]   = 1;
            end else if (!(gate_hs[h] || gate_ls[h])) begin
               gap[h]++;
            end
            p_hs[h] = gate_hs[h];
            p_ls[h] = gate_ls[h];
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Driver: queue one expectation for the coming falling edge
   task automatic expect_now(input string tag, input logic [6:0] exp, input logic [6:0] mask = 7'h7F);
      item_t it;
      it.tag  = tag;
      it.exp  = exp;
      it.mask = mask;
      sb_q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic do_step();
      @(posedge clk); #1 step_pulse = 1'b1;
      @(posedge clk); #1 step_pulse = 1'b0;
   endtask

   task automatic trip();
      @(posedge clk); #1 hs_over_lim = 1'b1;
      @(posedge clk); #1 hs_over_lim = 1'b0;
   endtask

   // Watchdog
   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      tick(4);
      expect_now("R1 in reset", 7'b00_00_0_1_0);
      rst_n = 1'b1;
      tick(2);
      expect_now("R1 after reset", 7'b00_00_0_1_0);

      // Forward drive, slow decay
      bridge_en = 1'b1;
      do_step();
      tick(8);
      expect_now("R2 fwd drive / R9 duty", 7'b01_10_1_1_0);
      trip();
      tick(8);
      expect_now("R3 R4 slow decay", 7'b11_00_0_1_0);
      tick(10);
      expect_now("R3 off-time holds", 7'b11_00_0_1_0);

      // Reverse drive, fast decay
      dir_fwd = 1'b0;
      do_step();
      tick(8);
      expect_now("R2 rev drive", 7'b10_01_1_1_0);
      decay_sel = 2'd1;
      trip();
      tick(8);
      expect_now("R5 fast rev", 7'b01_10_0_1_0);
      tick(20);
      expect_now("R5 fast held", 7'b01_10_0_1_0);

      // Mixed, fixed time, longest dead time
      dir_fwd   = 1'b1;
      slew_sel  = 2'd3;
      decay_sel = 2'd2;
      mix_by_sense = 1'b0;
      fast_time = 6'd20;
      do_step();
      tick(12);
      expect_now("R2 fwd drive slew3", 7'b01_10_1_1_0);
      trip();
      tick(12);
      expect_now("R6 mixed fast part", 7'b10_01_0_1_0);
      tick(22);
      expect_now("R6 mixed fixed -> slow", 7'b11_00_0_1_0);

      // Mixed, ended by low-side sense
      slew_sel = 2'd0;
      mix_by_sense = 1'b1;
      fast_time = 6'd63;
      do_step();
      tick(8);
      trip();
      tick(8);
      expect_now("R6 mixed sense fast part", 7'b10_01_0_1_0);
      ls_under_lim = 1'b1;
      tick(8);
      expect_now("R6 mixed sense -> slow", 7'b11_00_0_1_0);
      ls_under_lim = 1'b0;

      // Auto decay
      decay_sel = 2'd3;
      mix_by_sense = 1'b0;
      fast_time = 6'd20;
      limit_mag = 5'd20;
      do_step();
      tick(8);
      trip();
      tick(8);
      expect_now("R7 auto rising -> slow", 7'b11_00_0_1_0);
      limit_mag = 5'd5;
      do_step();
      tick(8);
      trip();
      tick(8);
      expect_now("R7 auto falling -> fast part", 7'b10_01_0_1_0);

      // Duty enable
      do_step();
      tick(8);
      pwm_out_en = 1'b0;
      expect_now("R9 duty disabled", 7'b01_10_0_0_0);
      pwm_out_en = 1'b1;
      tick(1);
      expect_now("R9 duty re-enabled", 7'b01_10_1_1_0);

      // Disable in the middle of drive
      @(posedge clk); #1 bridge_en = 1'b0;
      expect_now("R11 same-cycle off", 7'b00_00_0_1_0);
      tick(10);
      expect_now("R11 stays off", 7'b00_00_0_1_0);
      bridge_en = 1'b1;
      tick(8);
      expect_now("R11 restart drive", 7'b01_10_1_1_0);

      // Open-load window
      decay_sel = 2'd0;
      do_step();
      tick(13 * 64);
      expect_now("R10 below window", 7'b01_10_1_1_0);
      tick(4 * 64);
      expect_now("R10 flag set", 7'b01_10_1_1_1);
      trip();
      tick(70);
      expect_now("R10 cleared by reached period", 7'b00_00_0_0_0, 7'b00_00_0_0_1);

      tick(4);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule